// File: doc/BRIEF.md
# PCI Bus Target Responder

This block is a simplified 32-bit PCI target. It watches the multiplexed address/data bus for the start of a transaction. In the address phase it decodes the command and the address and decides whether to claim the transaction. A claimed transaction is served from one of three places: a 256-byte I/O store, a 256-byte memory store, or a small configuration space. The configuration space holds an identity word and the base register that sets where the two stores answer on the bus.

The block supports single and burst transfers. A burst moves one 32-bit word per data phase at consecutive word addresses. The block disconnects when a burst runs off the end of a store, and after a full 8-word line on a memory-read-line command. Side-band inputs let a test environment inject behaviour on a per-transaction basis: a programmable number of initial TRDY wait states, a termination mode (retry, abort after one word, or abort with no data), and a forced parity error on read data. All of these inputs are sampled in the address phase. The bus is presented as separate input and output halves with an output-enable, so that a pad ring or bus model can merge them.

Top module: `pci_target`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high and ad_oe is low. The base register is unprogrammed, so no I/O or memory command is claimed until a configuration write has set it.
- R2: Configuration reads (command 10) and writes (command 11) are claimed only while idsel is high in the address phase. Address bits [7:2] select the word. Word 0 reads the DEV_ID parameter. Word 4 (offset 0x10) is the base register, and its low 8 bits always read zero. Every other word reads zero and ignores writes.
- R3: I/O commands 2 and 3 and memory commands 6, 7, 12, 14 and 15 are claimed only when address bits [31:8] equal base bits [31:8] and the base has been programmed. Any other command or address leaves DEVSEL# high, which the master sees as a master abort.
- R4: I/O commands use the I/O store and memory commands use the memory store. These are two separate 64-word stores, and address bits [7:2] select the word.
- R5: In a burst, each data phase moves the next consecutive word. The transaction ends at a transfer that happens while FRAME# is high.
- R6: After word 63 of a store has transferred with FRAME# still low, the target disconnects: STOP# goes low while TRDY# stays high and DEVSEL# stays low.
- R7: Memory read line (command 14) returns exactly 8 words and then disconnects in the same way as R6.
- R8: With wait_cycles = W sampled at the address phase, TRDY# is first asserted exactly W clocks after the first data-phase clock.
- R9: Termination mode 1 (retry) asserts STOP# with DEVSEL# low, never asserts TRDY#, and moves no data.
- R10: Termination mode 2 (abort with data) transfers exactly one word. It then asserts STOP# with DEVSEL# high.
- R11: Termination mode 3 (abort without data) asserts STOP# with DEVSEL# high before any word transfers. Mode 0 is normal operation.
- R12: par_out is the even parity of ad_out together with cbe_n. With force_par set on a read, par_out is inverted on the data words and the transaction ends as in R10. On a write, force_par has no effect.
- R13: TRDY# and STOP# are never low together, and TRDY# is low only while DEVSEL# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Transaction framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| ad_in | input | 32 | Address/data bus as seen by the target |
| wait_cycles | input | 4 | Initial TRDY# wait states for the next transaction |
| term_sel | input | 2 | Termination mode: 0 normal, 1 retry, 2 abort with data, 3 abort without data |
| force_par | input | 1 | Corrupt read-data parity and abort |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target drives ad_out |
| par_out | output | 1 | Parity over ad_out and cbe_n |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |

## Verification
The assertions watch the handshake on every clock. They check that TRDY# and STOP# are exclusive, that TRDY# only appears under DEVSEL#, that an unclaimed address phase leaves DEVSEL# high, and that a requested wait holds TRDY# off in the first data clock. They also check that abort-with-data stops after its single word and that running off word 63 produces a disconnect. Data integrity across the two stores, the configuration identity and base masking, the exact wait latency for each count, the 8-word line limit, the effect of moving the base, and the fact that retry and abort leave memory unchanged are all matters of stored values over whole transactions. Only the bench scenarios can show these, by sweeping every word of both stores and each wait count.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {SP_NONE, SP_IO, SP_MEM, SP_CFG} space_e;
  typedef enum logic [1:0] {TM_NORMAL, TM_RETRY, TM_ABORT_DATA, TM_ABORT_NODATA} term_e;

  localparam logic [3:0] CMD_IO_RD   = 4'd2;
  localparam logic [3:0] CMD_IO_WR   = 4'd3;
  localparam logic [3:0] CMD_MEM_RD  = 4'd6;
  localparam logic [3:0] CMD_MEM_WR  = 4'd7;
  localparam logic [3:0] CMD_CFG_RD  = 4'd10;
  localparam logic [3:0] CMD_CFG_WR  = 4'd11;
  localparam logic [3:0] CMD_MEM_RDM = 4'd12;
  localparam logic [3:0] CMD_MEM_RDL = 4'd14;
  localparam logic [3:0] CMD_MEM_WRI = 4'd15;

  // which store a command addresses
  function automatic space_e cmd_space(input logic [3:0] cmd);
    case (cmd)
      CMD_IO_RD, CMD_IO_WR: return SP_IO;
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM, CMD_MEM_RDL, CMD_MEM_WRI: return SP_MEM;
      CMD_CFG_RD, CMD_CFG_WR: return SP_CFG;
      default: return SP_NONE;
    endcase
  endfunction

  function automatic logic cmd_reads(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_MEM_RD) || (cmd == CMD_CFG_RD) ||
           (cmd == CMD_MEM_RDM) || (cmd == CMD_MEM_RDL);
  endfunction

  // even parity across data and byte lanes
  function automatic logic bus_parity(input logic [31:0] ad, input logic [3:0] be);
    return ^{ad, be};
  endfunction
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic [3:0]        cmd,
  input  logic [31-BLK_W:0] addr_hi,
  input  logic              idsel,
  input  logic [31-BLK_W:0] bar_hi,
  input  logic              bar_valid,
  output logic              claim,
  output space_e            space,
  output logic              is_rd
);
  always_comb begin
    space = cmd_space(cmd);
    is_rd = cmd_reads(cmd);
    case (space)
      SP_CFG:       claim = idsel;
      SP_IO, SP_MEM: claim = bar_valid && (addr_hi == bar_hi);
      default:      claim = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_tgt_store.sv
module pci_tgt_store
  import pci_tgt_pkg::*;
#(
  parameter int          WORDS  = 64,
  parameter int          IDX_W  = 6,
  parameter int          BLK_W  = 8,
  parameter logic [31:0] DEV_ID = 32'h1F2E_3D4C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  space_e           space,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [31:0]      bar,
  output logic             bar_valid
);
  localparam logic [IDX_W-1:0] BAR_IDX  = IDX_W'(4);
  localparam logic [31:0]      BLK_MASK = (32'd1 << BLK_W) - 32'd1;

  logic [31:0] io_mem  [WORDS];
  logic [31:0] mem_mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en && space == SP_IO)  io_mem[idx]  <= wdata;
    if (wr_en && space == SP_MEM) mem_mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar       <= '0;
      bar_valid <= 1'b0;
    end else if (wr_en && space == SP_CFG && idx == BAR_IDX) begin
      bar       <= wdata & ~BLK_MASK;
      bar_valid <= 1'b1;
    end
  end

  always_comb begin
    case (space)
      SP_IO:  rdata = io_mem[idx];
      SP_MEM: rdata = mem_mem[idx];
      SP_CFG: rdata = (idx == '0) ? DEV_ID : (idx == BAR_IDX) ? bar : '0;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int IDX_W      = 6,
  parameter int LINE_WORDS = 8,
  parameter int WAIT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cmd,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              claim,
  input  space_e            space,
  input  logic              is_rd,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [1:0]        term_sel,
  input  logic              force_par,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              ad_oe,
  output logic              corrupt_par,
  output logic              wr_en,
  output space_e            cur_space,
  output logic [IDX_W-1:0]  cur_idx
);
  typedef enum logic {ST_IDLE, ST_DATA} st_e;
  localparam logic [IDX_W:0] LINE_CNT = (IDX_W+1)'(LINE_WORDS);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(WORDS - 1);

  st_e               st_q;
  space_e            space_q;
  term_e             mode_q;
  logic              frame_q, rd_q, perr_q, line_q;
  logic [IDX_W:0]    idx_q, beats_q;
  logic [WAIT_W-1:0] cnt_q;

  // named internal events
  logic addr_phase, ready, past_end, line_done, stop_req, is_abort;
  logic trdy_on, stop_on, devsel_on, xfer;

  assign addr_phase = (st_q == ST_IDLE) && !frame_n && frame_q;
  assign ready      = (st_q == ST_DATA) && (cnt_q == '0);
  assign past_end   = idx_q[IDX_W];
  assign line_done  = line_q && (beats_q == LINE_CNT);
  assign is_abort   = (mode_q == TM_ABORT_DATA) || (mode_q == TM_ABORT_NODATA);

  always_comb begin
    case (mode_q)
      TM_NORMAL:     stop_req = past_end || line_done;
      TM_ABORT_DATA: stop_req = (beats_q != '0);
      default:       stop_req = 1'b1;
    endcase
  end

  assign trdy_on   = ready && !stop_req;
  assign stop_on   = ready && stop_req;
  assign devsel_on = (st_q == ST_DATA) && !(stop_on && is_abort);
  assign xfer      = trdy_on && !irdy_n;

  assign devsel_n    = !devsel_on;
  assign trdy_n      = !trdy_on;
  assign stop_n      = !stop_on;
  assign ad_oe       = (st_q == ST_DATA) && rd_q;
  assign corrupt_par = perr_q;
  assign wr_en       = xfer && !rd_q;
  assign cur_space   = space_q;
  assign cur_idx     = idx_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      frame_q <= 1'b1;
      space_q <= SP_NONE;
      mode_q  <= TM_NORMAL;
      rd_q    <= 1'b0;
      perr_q  <= 1'b0;
      line_q  <= 1'b0;
      idx_q   <= '0;
      beats_q <= '0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_n;
      if (addr_phase && claim) begin
        st_q    <= ST_DATA;
        space_q <= space;
        rd_q    <= is_rd;
        idx_q   <= {1'b0, start_idx};
        beats_q <= '0;
        cnt_q   <= wait_cycles;
        perr_q  <= force_par && is_rd;
        mode_q  <= (force_par && is_rd) ? TM_ABORT_DATA : term_e'(term_sel);
        line_q  <= (cmd == CMD_MEM_RDL);
      end else if (st_q == ST_DATA) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (xfer) begin
          idx_q   <= idx_q + 1'b1;
          beats_q <= beats_q + 1'b1;
        end
        if ((xfer || stop_on) && frame_n) begin
          st_q   <= ST_IDLE;
          perr_q <= 1'b0;
        end
      end
    end
  end

  // R13
  trdy_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));
  // R13
  trdy_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
  // R3
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && !claim |=> devsel_n);
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && claim && wait_cycles != '0 |=> trdy_n);
  // R10
  abd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && mode_q == TM_ABORT_DATA |=> trdy_n);
  // R6
  end_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && idx_q == LAST_IDX && !frame_n && mode_q == TM_NORMAL |=> (!stop_n && trdy_n && !devsel_n));
endmodule

// File: rtl/pci_target.sv
module pci_target
  import pci_tgt_pkg::*;
#(
  parameter int          SPACE_BYTES = 256,
  parameter int          LINE_WORDS  = 8,
  parameter int          WAIT_W      = 4,
  parameter logic [31:0] DEV_ID      = 32'h1F2E_3D4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              idsel,
  input  logic [3:0]        cbe_n,
  input  logic [31:0]       ad_in,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [1:0]        term_sel,
  input  logic              force_par,
  output logic [31:0]       ad_out,
  output logic              ad_oe,
  output logic              par_out,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n
);
  localparam int WORDS = SPACE_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);
  localparam int BLK_W = $clog2(SPACE_BYTES);

  logic             claim, is_rd, wr_en, corrupt_par, bar_valid;
  space_e           dec_space, cur_space;
  logic [IDX_W-1:0] cur_idx;
  logic [31:0]      rdata, bar;

  pci_tgt_decode #(.BLK_W(BLK_W)) u_dec (
    .cmd(cbe_n), .addr_hi(ad_in[31:BLK_W]), .idsel(idsel),
    .bar_hi(bar[31:BLK_W]), .bar_valid(bar_valid),
    .claim(claim), .space(dec_space), .is_rd(is_rd)
  );

  pci_tgt_ctrl #(.WORDS(WORDS), .IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cmd(cbe_n),
    .start_idx(ad_in[IDX_W+1:2]), .claim(claim), .space(dec_space), .is_rd(is_rd),
    .wait_cycles(wait_cycles), .term_sel(term_sel), .force_par(force_par),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe),
    .corrupt_par(corrupt_par), .wr_en(wr_en), .cur_space(cur_space), .cur_idx(cur_idx)
  );

  pci_tgt_store #(.WORDS(WORDS), .IDX_W(IDX_W), .BLK_W(BLK_W), .DEV_ID(DEV_ID)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .space(cur_space), .idx(cur_idx),
    .wdata(ad_in), .rdata(rdata), .bar(bar), .bar_valid(bar_valid)
  );

  assign ad_out  = ad_oe ? rdata : '0;
  assign par_out = bus_parity(ad_out, cbe_n) ^ (ad_oe && corrupt_par);
endmodule

// File: tb/pci_target_test.sv
module pci_target_test;
  localparam logic [31:0] DEV_ID = 32'h1F2E_3D4C;
  localparam logic [31:0] BASE_A = 32'h0000_5A00;
  localparam logic [31:0] BASE_B = 32'h0000_7700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, force_par = 1'b0;
  logic [3:0]  cbe_n = 4'h0;
  logic [31:0] ad_in = '0;
  logic [3:0]  wait_cycles = '0;
  logic [1:0]  term_sel = '0;
  logic [31:0] ad_out;
  logic ad_oe, par_out, devsel_n, trdy_n, stop_n;

  always #10 clk = ~clk;

  pci_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .wait_cycles(wait_cycles), .term_sel(term_sel),
    .force_par(force_par), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] wbuf [64];
  logic [31:0] rbuf [64];
  logic [31:0] exp_mem [64];
  logic [31:0] exp_io [64];
  int r_k, r_lat;
  logic r_stop, r_abort, r_ma, r_perr;

  function automatic logic [31:0] mem_pat(input int i, input int s);
    return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203) ^ (32'(s) << 20);
  endfunction
  function automatic logic [31:0] io_pat(input int i);
    return (32'(i) * 32'h0100_0193) ^ 32'h0000_003C;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel, input int n);
    int k, idle;
    logic done, dv, tr, sp, pr;
    logic [31:0] rd;
    r_stop = 0; r_abort = 0; r_ma = 0; r_perr = 0; r_lat = -1;
    @(posedge clk); #5;
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(posedge clk); #5;
    irdy_n = 1'b0; cbe_n = 4'h0; idsel = 1'b0; frame_n = (n == 1); ad_in = wbuf[0];
    k = 0; idle = 0; done = 0;
    for (int it = 0; it < 200 && !done; it++) begin
      @(negedge clk);
      dv = devsel_n; tr = trdy_n; sp = stop_n; rd = ad_out; pr = par_out;
      @(posedge clk); #5;
      if (!tr) begin
        if (r_lat < 0) r_lat = it;
        rbuf[k] = rd;
        if (pr !== ^rd) r_perr = 1;
        k++;
        if (k == n) done = 1;
        else begin ad_in = wbuf[k]; frame_n = (k == n - 1); end
      end else if (!sp) begin
        r_stop = 1;
        if (dv) r_abort = 1;
        if (frame_n) done = 1; else frame_n = 1'b1;
      end else if (dv) begin
        idle++;
        if (idle >= 5) begin r_ma = 1; done = 1; end
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; r_k = k;
    @(posedge clk); #5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset outputs", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    // R1 no claim before base programmed
    wbuf[0] = 32'h1234_5678;
    txn(4'd7, 32'h0000_0010, 1'b0, 1);
    check("R1", "unprogrammed master abort", {31'd0, r_ma}, 32'd1);

    // R2 configuration
    wbuf[0] = BASE_A | 32'hFF;
    txn(4'd11, 32'h10, 1'b1, 1);
    check("R2", "cfg write accepted", 32'(r_k), 32'd1);
    txn(4'd10, 32'h10, 1'b1, 1);
    check("R2", "base readback masked", rbuf[0], BASE_A);
    txn(4'd10, 32'h00, 1'b1, 1);
    check("R2", "identity word", rbuf[0], DEV_ID);
    wbuf[0] = 32'hDEAD_BEEF;
    txn(4'd11, 32'h08, 1'b1, 1);
    txn(4'd10, 32'h08, 1'b1, 1);
    check("R2", "other cfg word reads zero", rbuf[0], 32'h0);
    txn(4'd10, 32'h10, 1'b0, 1);
    check("R2", "cfg without idsel", {31'd0, r_ma}, 32'd1);
    // R3 unsupported command / other address
    txn(4'd1, BASE_A, 1'b0, 1);
    check("R3", "unsupported cmd", {31'd0, r_ma}, 32'd1);
    txn(4'd6, BASE_A + 32'h100, 1'b0, 1);
    check("R3", "address miss", {31'd0, r_ma}, 32'd1);

    // R5 full memory burst write then burst read
    for (int i = 0; i < 64; i++) begin wbuf[i] = mem_pat(i, 0); exp_mem[i] = wbuf[i]; end
    txn(4'd7, BASE_A, 1'b0, 64);
    check("R5", "burst write count", 32'(r_k), 32'd64);
    check("R5", "burst write no stop", {31'd0, r_stop}, 32'd0);
    txn(4'd12, BASE_A, 1'b0, 64);
    check("R5", "burst read count", 32'(r_k), 32'd64);
    for (int i = 0; i < 64; i++) check("R5", "burst read word", rbuf[i], exp_mem[i]);
    check("R12", "read parity clean", {31'd0, r_perr}, 32'd0);

    // R4 I/O store sweep with single transfers
    for (int i = 0; i < 64; i++) begin
      wbuf[0] = io_pat(i); exp_io[i] = wbuf[0];
      txn(4'd3, BASE_A + 32'(4 * i), 1'b0, 1);
    end
    for (int i = 0; i < 64; i++) begin
      txn(4'd2, BASE_A + 32'(4 * i), 1'b0, 1);
      check("R4", "io word", rbuf[0], exp_io[i]);
    end
    txn(4'd6, BASE_A + 32'd20, 1'b0, 1);
    check("R4", "memory untouched by io", rbuf[0], exp_mem[5]);

    // R6 disconnect at end of store
    txn(4'd12, BASE_A + 32'd240, 1'b0, 8);
    check("R6", "words before end", 32'(r_k), 32'd4);
    check("R6", "stop seen", {31'd0, r_stop}, 32'd1);
    check("R6", "devsel kept", {31'd0, r_abort}, 32'd0);
    for (int i = 0; i < 4; i++) check("R6", "tail word", rbuf[i], exp_mem[60 + i]);

    // R7 memory read line
    txn(4'd14, BASE_A + 32'd32, 1'b0, 12);
    check("R7", "line length", 32'(r_k), 32'd8);
    check("R7", "line disconnect", {31'd0, r_stop && !r_abort}, 32'd1);
    for (int i = 0; i < 8; i++) check("R7", "line word", rbuf[i], exp_mem[8 + i]);

    // R8 wait sweep
    for (int w = 0; w < 8; w++) begin
      wait_cycles = 4'(w);
      txn(4'd6, BASE_A + 32'(4 * w), 1'b0, 1);
      check("R8", "wait latency", 32'(r_lat), 32'(w));
      check("R8", "data after wait", rbuf[0], exp_mem[w]);
    end
    wait_cycles = '0;

    // R9 retry
    term_sel = 2'd1; wbuf[0] = 32'hCAFE_0001;
    txn(4'd7, BASE_A + 32'd120, 1'b0, 1);
    term_sel = 2'd0;
    check("R9", "retry words", 32'(r_k), 32'd0);
    check("R9", "retry stop with devsel", {30'd0, r_stop, r_abort}, 32'h2);
    txn(4'd6, BASE_A + 32'd120, 1'b0, 1);
    check("R9", "retry left memory", rbuf[0], exp_mem[30]);

    // R10 abort with data
    term_sel = 2'd2;
    for (int i = 0; i < 4; i++) wbuf[i] = mem_pat(20 + i, 1);
    txn(4'd7, BASE_A + 32'd80, 1'b0, 4);
    term_sel = 2'd0;
    exp_mem[20] = wbuf[0];
    check("R10", "one word", 32'(r_k), 32'd1);
    check("R10", "abort flagged", {31'd0, r_abort}, 32'd1);
    txn(4'd12, BASE_A + 32'd80, 1'b0, 2);
    check("R10", "first word stored", rbuf[0], exp_mem[20]);
    check("R10", "second word kept", rbuf[1], exp_mem[21]);

    // R11 abort without data
    term_sel = 2'd3; wbuf[0] = 32'h0BAD_0BAD;
    txn(4'd7, BASE_A + 32'd160, 1'b0, 1);
    term_sel = 2'd0;
    check("R11", "no words", 32'(r_k), 32'd0);
    check("R11", "abort flagged", {31'd0, r_abort}, 32'd1);
    txn(4'd6, BASE_A + 32'd160, 1'b0, 1);
    check("R11", "memory kept", rbuf[0], exp_mem[40]);

    // R12 forced parity
    force_par = 1'b1;
    txn(4'd12, BASE_A + 32'd40, 1'b0, 4);
    check("R12", "parity read words", 32'(r_k), 32'd1);
    check("R12", "parity bad", {31'd0, r_perr}, 32'd1);
    check("R12", "parity abort", {31'd0, r_abort}, 32'd1);
    check("R12", "parity read data", rbuf[0], exp_mem[10]);
    wbuf[0] = 32'h5555_AAAA; exp_mem[11] = wbuf[0];
    txn(4'd7, BASE_A + 32'd44, 1'b0, 1);
    force_par = 1'b0;
    check("R12", "write unaffected", {30'd0, r_stop, r_k == 1}, 32'h1);
    txn(4'd6, BASE_A + 32'd44, 1'b0, 1);
    check("R12", "write stored", rbuf[0], exp_mem[11]);
    check("R12", "parity clean again", {31'd0, r_perr}, 32'd0);

    // R3 move the base
    wbuf[0] = BASE_B;
    txn(4'd11, 32'h10, 1'b1, 1);
    txn(4'd6, BASE_A + 32'd12, 1'b0, 1);
    check("R3", "old base released", {31'd0, r_ma}, 32'd1);
    txn(4'd6, BASE_B + 32'd12, 1'b0, 1);
    check("R3", "new base claims", rbuf[0], exp_mem[3]);
    // R13 idle outputs after all traffic
    @(negedge clk);
    check("R13", "idle handshake", {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule